// File: doc/BRIEF.md
# Shared-Pin Strap Capture

This block reads a board-level configuration from pins that later carry clock outputs. While the synchronous power-on reset is held, the pin drivers stay disabled and each pin level passes through a synchronizer. A pin that nothing drives reads as its pull default. On the final clock edge that still sees reset, the synchronized five-bit word is loaded into a configuration register. The register then stays fixed until the next power-on reset.

After reset ends, the block raises a configuration-valid flag. One clock later it enables the pin drivers, and the pins then carry the clock waveforms handed to the block. The captured word is split into a four-bit frequency code and an active-low free-running select for processor clock 0. From the frequency code the block derives the processor-to-bus ratio. A separate active-low quarter-rate request is synchronized and reported, so that downstream dividers can slow the processor and bus clocks by four.

Top module: `strap_capture_top`

## Requirements
- R1: While reset is asserted, every pin output enable is 0, every pin drive value is 0, `cfg_valid_o` is 0 and `quarter_mode_o` is 0.
- R2: The captured pin word is the synchronized level at the last clock edge with reset high, for pin levels held for at least three edges before it. Word bits 3..0 give `fsel_o` 3..0. Word bit 4 is the active-low free-running select, so `cpu0_free_o` is the inverse of bit 4.
- R3: A pin flagged as undriven in `strap_float_i` reads as its pull default. Bits 0, 1, 3 and 4 default to 1 and bit 2 defaults to 0, so a fully floating strap gives `fsel_o` = 4'b1011 and `cpu0_free_o` = 0.
- R4: `cfg_valid_o` becomes 1 at the first clock edge that sees reset low. `pin_oe_o` becomes all ones one edge later.
- R5: Once the pins are enabled, `pin_drive_o` equals `clk_src_i` bit for bit. Before that it is 0.
- R6: After reset, changes on `strap_pin_i` or `strap_float_i` have no effect on `fsel_o` or `cpu0_free_o`.
- R7: A new reset pulse captures the pin levels again and repeats the enable sequence.
- R8: Outside reset, `quarter_mode_o` equals the inverse of `quarter_n_i` as it was two clock edges earlier.
- R9: `ratio_o` encodes the processor-to-bus ratio from `fsel_o` bits 3..2: 00 gives 2'd0 (2:1, so code 4'b0011 gives 2:1), 11 gives 2'd2 (4:1), and any other value gives 2'd1 (3:1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_pin_i | input | 5 | Level seen on each shared pin |
| strap_float_i | input | 5 | 1 where the pin is undriven and reads its pull default |
| clk_src_i | input | 5 | Clock waveform to place on each pin after capture |
| quarter_n_i | input | 1 | Active-low quarter-rate request |
| pin_drive_o | output | 5 | Value driven onto each pin |
| pin_oe_o | output | 5 | Output enable for each pin |
| cfg_valid_o | output | 1 | Captured configuration is valid |
| fsel_o | output | 4 | Captured frequency-select code |
| cpu0_free_o | output | 1 | Processor clock 0 runs free of stop requests |
| ratio_o | output | 2 | Processor-to-bus ratio code |
| quarter_mode_o | output | 1 | Synchronized quarter-rate mode |

## Verification
The assertions assume that reset is held for at least one edge, so the capture edge and the enable sequence are defined. They also take the strap levels as steady over the synchronizer depth before reset falls. When that does not hold, the captured word is undefined but the register stays frozen. The stimulus sets pin levels at a falling clock edge, holds reset for six edges before releasing it, and changes the pins only after the drivers are on.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    localparam int NUM_STRAPS = 5;
    localparam int FSEL_W     = 4;

    // Pull defaults: bit 2 pulls low, all others pull high.
    localparam logic [NUM_STRAPS-1:0] PULL_DEFAULT = 5'b11011;

    typedef enum logic [1:0] {
        PH_STRAP  = 2'd0,
        PH_SETTLE = 2'd1,
        PH_DRIVE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RATIO_2TO1 = 2'd0,
        RATIO_3TO1 = 2'd1,
        RATIO_4TO1 = 2'd2
    } ratio_e;

    typedef struct packed {
        logic              sel_free_n;
        logic [FSEL_W-1:0] fsel;
    } strap_word_t;

    function automatic strap_word_t resolve_pins(
        input logic [NUM_STRAPS-1:0] level,
        input logic [NUM_STRAPS-1:0] floating
    );
        logic [NUM_STRAPS-1:0] merged;
        merged = (level & ~floating) | (PULL_DEFAULT & floating);
        return strap_word_t'(merged);
    endfunction

    function automatic ratio_e ratio_of(input logic [FSEL_W-1:0] code);
        ratio_e r;
        case (code[FSEL_W-1:FSEL_W-2])
            2'b00:   r = RATIO_2TO1;
            2'b11:   r = RATIO_4TO1;
            default: r = RATIO_3TO1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter bit               HAS_RESET = 1'b0,
    parameter logic [WIDTH-1:0] RST_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (HAS_RESET) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
                end else begin
                    chain_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
                end
            end
        end else begin : g_free
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                chain_q[0] <= d;
                for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  strap_word_t sampled,
    output strap_word_t cfg,
    output logic        valid,
    output logic        drive_en
);
    phase_e      phase_q;
    strap_word_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STRAP;
            cfg_q   <= sampled;
        end else begin
            case (phase_q)
                PH_STRAP:  phase_q <= PH_SETTLE;
                PH_SETTLE: phase_q <= PH_DRIVE;
                default:   phase_q <= PH_DRIVE;
            endcase
        end
    end

    assign cfg      = cfg_q;
    assign valid    = (phase_q != PH_STRAP);
    assign drive_en = (phase_q == PH_DRIVE);

    // R6: the held word never moves once out of the strap phase
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_STRAP) |=> $stable(cfg_q));

    // R4: drivers still off on the first edge after reset, settle then drive
    p_oe_after_valid_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!drive_en && !valid));

    p_settle_to_drive_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SETTLE) |=> drive_en);
endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
    parameter int NUM_PINS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                drive_en,
    input  logic [NUM_PINS-1:0] clk_src,
    output logic [NUM_PINS-1:0] pin_drive,
    output logic [NUM_PINS-1:0] pin_oe
);
    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            assign pin_oe[p]    = drive_en;
            assign pin_drive[p] = drive_en & clk_src[p];
        end
    endgenerate

    // R5: no level reaches a pin while its driver is off
    p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == '0) |-> (pin_drive == '0));

    // R5: enables switch together
    p_oe_uniform_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe == '0) || (pin_oe == '1));
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
    import strap_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STRAPS-1:0] strap_pin_i,
    input  logic [NUM_STRAPS-1:0] strap_float_i,
    input  logic [NUM_STRAPS-1:0] clk_src_i,
    input  logic                  quarter_n_i,
    output logic [NUM_STRAPS-1:0] pin_drive_o,
    output logic [NUM_STRAPS-1:0] pin_oe_o,
    output logic                  cfg_valid_o,
    output logic [FSEL_W-1:0]     fsel_o,
    output logic                  cpu0_free_o,
    output logic [1:0]            ratio_o,
    output logic                  quarter_mode_o
);
    strap_word_t           resolved;
    logic [NUM_STRAPS-1:0] synced;
    strap_word_t           held;
    logic                  drive_en;
    logic                  quarter_sync;

    assign resolved = resolve_pins(strap_pin_i, strap_float_i);

    strap_sync #(
        .WIDTH(NUM_STRAPS), .STAGES(SYNC_STAGES), .HAS_RESET(1'b0), .RST_VAL('0)
    ) pin_sync_i (
        .clk(clk), .rst(rst), .d(resolved), .q(synced)
    );

    strap_sync #(
        .WIDTH(1), .STAGES(SYNC_STAGES), .HAS_RESET(1'b1), .RST_VAL(1'b0)
    ) quarter_sync_i (
        .clk(clk), .rst(rst), .d(~quarter_n_i), .q(quarter_sync)
    );

    strap_latch latch_i (
        .clk(clk), .rst(rst), .sampled(strap_word_t'(synced)),
        .cfg(held), .valid(cfg_valid_o), .drive_en(drive_en)
    );

    strap_pad_ctrl #(.NUM_PINS(NUM_STRAPS)) pad_i (
        .clk(clk), .rst(rst), .drive_en(drive_en), .clk_src(clk_src_i),
        .pin_drive(pin_drive_o), .pin_oe(pin_oe_o)
    );

    assign fsel_o         = held.fsel;
    assign cpu0_free_o    = ~held.sel_free_n;
    assign ratio_o        = ratio_of(held.fsel);
    assign quarter_mode_o = quarter_sync;

    // R9: the low-speed code pair always maps to the double ratio
    p_ratio_low_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid_o && fsel_o[3:2] == 2'b00) |-> (ratio_o == RATIO_2TO1));

    // R4: drivers are never on without a valid configuration
    p_oe_needs_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o != '0) |-> cfg_valid_o);
endmodule

// File: tb/strap_capture_top_tb_top.sv
module strap_capture_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] strap_pin = '0;
    logic [4:0] strap_float = '0;
    logic [4:0] clk_src = 5'b10110;
    logic       quarter_n = 1'b1;
    logic [4:0] pin_drive, pin_oe;
    logic       cfg_valid, cpu0_free, quarter_mode;
    logic [3:0] fsel;
    logic [1:0] ratio;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    strap_capture_top dut_i (
        .clk(clk), .rst(rst), .strap_pin_i(strap_pin), .strap_float_i(strap_float),
        .clk_src_i(clk_src), .quarter_n_i(quarter_n), .pin_drive_o(pin_drive),
        .pin_oe_o(pin_oe), .cfg_valid_o(cfg_valid), .fsel_o(fsel),
        .cpu0_free_o(cpu0_free), .ratio_o(ratio), .quarter_mode_o(quarter_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply a strap pattern under reset, check reset state, release, check sequence.
    task automatic power_on(input logic [4:0] pins, input logic [4:0] flt,
                            input logic [3:0] exp_fsel, input logic exp_free);
        @(negedge clk);
        rst = 1'b1; strap_pin = pins; strap_float = flt;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R1 oe in reset", pin_oe, 0);
        check("R1 drive in reset", pin_drive, 0);
        check("R1 valid in reset", cfg_valid, 0);
        check("R1 quarter in reset", quarter_mode, 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R4 valid first edge", cfg_valid, 1);
        check("R4 oe still off", pin_oe, 0);
        check("R5 drive off before oe", pin_drive, 0);
        check("R2 fsel", fsel, exp_fsel);
        check("R2 free select", cpu0_free, exp_free);
        @(posedge clk); @(negedge clk);
        check("R4 oe on", pin_oe, 5'b11111);
    endtask

    task automatic t_capture_r2;
        power_on(5'b00011, 5'b00000, 4'b0011, 1'b1);
        check("R9 ratio 2:1", ratio, 0);
        power_on(5'b11101, 5'b00000, 4'b1101, 1'b0);
        check("R9 ratio 4:1", ratio, 2);
    endtask

    task automatic t_defaults_r3;
        power_on(5'b00100, 5'b11111, 4'b1011, 1'b0);
        check("R9 ratio 3:1", ratio, 1);
        power_on(5'b00000, 5'b00100, 4'b0000, 1'b1);
    endtask

    task automatic t_drive_r5;
        clk_src = 5'b01001;
        @(negedge clk);
        check("R5 drive follows", pin_drive, 5'b01001);
        clk_src = 5'b10110;
        @(negedge clk);
        check("R5 drive follows 2", pin_drive, 5'b10110);
    endtask

    task automatic t_hold_r6;
        logic [3:0] f0;
        logic       c0;
        f0 = fsel; c0 = cpu0_free;
        strap_pin = ~strap_pin; strap_float = 5'b01010;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R6 fsel held", fsel, f0);
        check("R6 free held", cpu0_free, c0);
    endtask

    task automatic t_recapture_r7;
        power_on(5'b00110, 5'b00000, 4'b0110, 1'b1);
        check("R7 ratio after recapture", ratio, 1);
    endtask

    task automatic t_quarter_r8;
        @(negedge clk);
        quarter_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 quarter one edge", quarter_mode, 0);
        @(posedge clk); @(negedge clk);
        check("R8 quarter two edges", quarter_mode, 1);
        quarter_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 quarter released", quarter_mode, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_capture_r2();
        t_defaults_r3();
        t_drive_r5();
        t_hold_r6();
        t_quarter_r8();
        t_recapture_r7();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule